// File: doc/BRIEF.md
# CCD Color Gain Steering Controller

This block picks, on every pixel clock, one of four programmable 9-bit gain values and hands it to a per-pixel gain stage that sits in front of the main amplifier of a CCD signal chain. The choice follows a Bayer color filter layout. Within one line the selected gain alternates pixel by pixel inside a pair: either the "low pair" (gain 0, gain 1) or the "high pair" (gain 2, gain 3). Across lines and fields, the pair in use depends on the readout mode.

The host supplies the vertical and horizontal sync strobes, a pixel-valid qualifier, a 2-bit mode select and two packed gain words. The block detects the falling edges of the sync strobes in its own clock domain. A field counter drives the choice of gain pair. In progressive readout the counter is cleared every frame. In interlaced readout it toggles, and each field is locked to one gain pair. In three-field readout it counts through 0, 1, 2 while the lines still alternate between pairs.

The outputs are the selected gain, its 2-bit index and the current field number.

Top module: `gain_steer_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, field_o is 0 and gain_idx_o is 0 (low pair, even pixel).
- R2: gain_o always equals the gain chosen by gain_idx_o. Index 0 is gain01_i[8:0], index 1 is gain01_i[17:9], index 2 is gain23_i[8:0] and index 3 is gain23_i[17:9]. A change of a gain word shows on gain_o in the same cycle.
- R3: gain_idx_o bit 0 is the pixel phase. It inverts on each clock edge where pix_vld_i is high and no sync falling edge is detected. It holds while pix_vld_i is low.
- R4: A sync falling edge is detected at the clock edge where the strobe is sampled low and was sampled high at the previous edge. Its effect appears on the outputs just after that edge. Rising edges, and strobes held at a steady level, have no effect.
- R5: In progressive mode (mode_i = 0), a VD falling edge sets field_o to 0 and selects the low pair. Each HD falling edge switches to the other pair.
- R6: In interlaced mode (mode_i = 1), a VD falling edge sets field_o to 0 if it was 1, and to 1 otherwise. Field 0 uses the low pair and field 1 uses the high pair. An HD falling edge re-selects the pair of the current field instead of switching.
- R7: In three-field mode (mode_i = 2), a VD falling edge steps field_o through 0, 1, 2, 0, and so on. Fields 0 and 2 start on the low pair and field 1 starts on the high pair. Each HD falling edge switches to the other pair.
- R8: When VD and HD fall on the same clock edge, only the VD action is taken.
- R9: Mode code 3 behaves exactly as progressive mode.
- R10: Every VD or HD falling edge returns the pixel phase to 0, so the first pixel of a line uses the even gain of the pair.
- R11: field_o never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vd_i | input | 1 | Vertical sync strobe |
| hd_i | input | 1 | Horizontal sync strobe |
| pix_vld_i | input | 1 | Pixel-valid qualifier; advances the pixel phase |
| mode_i | input | 2 | Readout mode: 0 progressive, 1 interlaced, 2 three-field, 3 progressive |
| gain01_i | input | 18 | Gain 0 in bits [8:0], gain 1 in bits [17:9] |
| gain23_i | input | 18 | Gain 2 in bits [8:0], gain 3 in bits [17:9] |
| gain_o | output | 9 | Selected per-pixel gain |
| gain_idx_o | output | 2 | Index of the selected gain (bit 1 = pair, bit 0 = pixel phase) |
| field_o | output | 2 | Current field number |

## Verification
The assertions check the following on every cycle:
- the gain output matches the index;
- the field counter stays in range;
- the pixel phase toggles on valid pixels;
- a VD fall in progressive, spare and three-field wrap leads to the expected field and pair;
- an interlaced field stays tied to its pair.

Some properties can only be shown through bench scenarios that run whole frames against the behavioural reference:
- complete field sequences across several frames;
- the alternation of pairs over many lines;
- how simultaneous VD and HD edges resolve;
- that held or rising strobes are ignored;
- switching between modes in mid-stream.

// File: rtl/gsteer_pkg.sv
package gsteer_pkg;
    localparam int GAIN_W    = 9;
    localparam int NUM_GAINS = 4;
    localparam int IDX_W     = $clog2(NUM_GAINS);
    localparam int FIELD_W   = 2;

    typedef enum logic [1:0] {
        MODE_PROG   = 2'd0,
        MODE_ILACE  = 2'd1,
        MODE_TRIPLE = 2'd2,
        MODE_SPARE  = 2'd3
    } mode_e;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               pair_hi;
        logic               phase;
    } steer_s;
endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_fall
        assign fall_o[i] = prev_q[i] & ~sync_i[i];
    end
endmodule

// File: rtl/steer_seq.sv
module steer_seq
    import gsteer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vd_fall_i,
    input  logic               hd_fall_i,
    input  logic               pix_vld_i,
    input  logic [1:0]         mode_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic [FIELD_W-1:0] field_o
);
    steer_s             st_d, st_q;
    logic [FIELD_W-1:0] field_nxt;
    mode_e              mode;

    assign mode = mode_e'(mode_i);

    always_comb begin
        unique case (mode)
            MODE_ILACE:  field_nxt = (st_q.field == FIELD_W'(1)) ? '0 : FIELD_W'(1);
            MODE_TRIPLE: field_nxt = (st_q.field >= FIELD_W'(2)) ? '0 : st_q.field + FIELD_W'(1);
            default:     field_nxt = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (vd_fall_i) begin
            st_d.field   = field_nxt;
            st_d.pair_hi = (field_nxt == FIELD_W'(1));
            st_d.phase   = 1'b0;
        end else if (hd_fall_i) begin
            st_d.phase = 1'b0;
            if (mode == MODE_ILACE) st_d.pair_hi = (st_q.field == FIELD_W'(1));
            else                    st_d.pair_hi = ~st_q.pair_hi;
        end else if (pix_vld_i) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o   = {st_q.pair_hi, st_q.phase};
    assign field_o = st_q.field;
endmodule

// File: rtl/gain_pick.sv
module gain_pick #(
    parameter int GAIN_W    = 9,
    parameter int NUM_GAINS = 4,
    localparam int IDX_W    = $clog2(NUM_GAINS)
) (
    input  logic [NUM_GAINS*GAIN_W-1:0] gains_i,
    input  logic [IDX_W-1:0]            idx_i,
    output logic [GAIN_W-1:0]           gain_o
);
    logic [GAIN_W-1:0] bank [NUM_GAINS];

    for (genvar g = 0; g < NUM_GAINS; g++) begin : g_unpack
        assign bank[g] = gains_i[g*GAIN_W +: GAIN_W];
    end

    assign gain_o = bank[idx_i];
endmodule

// File: rtl/gain_steer_top.sv
module gain_steer_top
    import gsteer_pkg::*;
#(
    parameter int GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vd_i,
    input  logic          hd_i,
    input  logic          pix_vld_i,
    input  logic [1:0]    mode_i,
    input  logic [2*GW-1:0] gain01_i,
    input  logic [2*GW-1:0] gain23_i,
    output logic [GW-1:0] gain_o,
    output logic [1:0]    gain_idx_o,
    output logic [1:0]    field_o
);
    logic [1:0] fall;

    sync_fall_det #(.N(2)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i ({hd_i, vd_i}),
        .fall_o (fall)
    );

    steer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vd_fall_i (fall[0]),
        .hd_fall_i (fall[1]),
        .pix_vld_i (pix_vld_i),
        .mode_i    (mode_i),
        .idx_o     (gain_idx_o),
        .field_o   (field_o)
    );

    gain_pick #(.GAIN_W(GW), .NUM_GAINS(NUM_GAINS)) u_pick (
        .gains_i ({gain23_i, gain01_i}),
        .idx_i   (gain_idx_o),
        .gain_o  (gain_o)
    );
endmodule

// File: rtl/gain_steer_chk.sv
module gain_steer_chk #(
    parameter int GW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vd_i,
    input logic          hd_i,
    input logic          pix_vld_i,
    input logic [1:0]    mode_i,
    input logic [2*GW-1:0] gain01_i,
    input logic [2*GW-1:0] gain23_i,
    input logic [GW-1:0] gain_o,
    input logic [1:0]    gain_idx_o,
    input logic [1:0]    field_o
);
    logic vd_seen_q, hd_seen_q;
    logic vd_fell, hd_fell;
    logic [GW-1:0] want_gain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_seen_q <= 1'b0;
            hd_seen_q <= 1'b0;
        end else begin
            vd_seen_q <= vd_i;
            hd_seen_q <= hd_i;
        end
    end

    assign vd_fell = vd_seen_q && !vd_i;
    assign hd_fell = hd_seen_q && !hd_i;

    always_comb begin
        case (gain_idx_o)
            2'd0:    want_gain = gain01_i[GW-1:0];
            2'd1:    want_gain = gain01_i[2*GW-1:GW];
            2'd2:    want_gain = gain23_i[GW-1:0];
            default: want_gain = gain23_i[2*GW-1:GW];
        endcase
    end

    always_comb begin
        if (rst_n) a_r2_gain_matches_index: assert (gain_o == want_gain);
    end

    a_r11_field_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        field_o != 2'd3);

    a_r3_phase_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld_i && !vd_fell && !hd_fell) |=> (gain_idx_o[0] != $past(gain_idx_o[0])));

    a_r5_prog_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_fell && (mode_i == 2'd0 || mode_i == 2'd3)) |=> (field_o == 2'd0 && gain_idx_o == 2'd0));

    a_r6_ilace_pair_follows_field: assert property (@(posedge clk) disable iff (!rst_n)
        ((vd_fell || hd_fell) && mode_i == 2'd1) |=> (gain_idx_o == {field_o[0], 1'b0}));

    a_r7_triple_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_fell && mode_i == 2'd2 && field_o == 2'd2) |=> (field_o == 2'd0 && gain_idx_o == 2'd0));

    a_r10_sync_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_fell || hd_fell) |=> (gain_idx_o[0] == 1'b0));
endmodule

bind gain_steer_top gain_steer_chk #(.GW(GW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vd_i       (vd_i),
    .hd_i       (hd_i),
    .pix_vld_i  (pix_vld_i),
    .mode_i     (mode_i),
    .gain01_i   (gain01_i),
    .gain23_i   (gain23_i),
    .gain_o     (gain_o),
    .gain_idx_o (gain_idx_o),
    .field_o    (field_o)
);

// File: tb/tb_gain_steer_top.sv
`timescale 1ns/1ps
module tb_gain_steer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vd = 1'b0, hd = 1'b0, pix_vld = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [17:0] g01 = '0, g23 = '0;
    logic [8:0]  gain;
    logic [1:0]  idx, field;

    int n_chk = 0, n_fail = 0;
    string cur_req = "R3";
    bit done = 0;

    // behavioural reference state
    int m_field = 0, m_pair = 0, m_phase = 0;
    bit m_vdp = 0, m_hdp = 0;

    always #2 clk = ~clk; // 250 MHz

    gain_steer_top dut (
        .clk(clk), .rst_n(rst_n), .vd_i(vd), .hd_i(hd), .pix_vld_i(pix_vld),
        .mode_i(mode), .gain01_i(g01), .gain23_i(g23),
        .gain_o(gain), .gain_idx_o(idx), .field_o(field)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int gain_of(int i);
        case (i)
            0: return int'(g01[8:0]);
            1: return int'(g01[17:9]);
            2: return int'(g23[8:0]);
            default: return int'(g23[17:9]);
        endcase
    endfunction

    always @(posedge clk) begin
        bit vf, hf;
        if (!rst_n) begin
            m_field = 0; m_pair = 0; m_phase = 0; m_vdp = 0; m_hdp = 0;
        end else begin
            vf = m_vdp && !vd;
            hf = m_hdp && !hd;
            if (vf) begin
                if (mode == 2'd1)      m_field = (m_field == 1) ? 0 : 1;
                else if (mode == 2'd2) m_field = (m_field + 1) % 3;
                else                   m_field = 0;
                m_pair = (m_field == 1) ? 1 : 0;
                m_phase = 0;
            end else if (hf) begin
                m_phase = 0;
                if (mode == 2'd1) m_pair = (m_field == 1) ? 1 : 0;
                else              m_pair = 1 - m_pair;
            end else if (pix_vld) begin
                m_phase = 1 - m_phase;
            end
            m_vdp = vd; m_hdp = hd;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(cur_req, int'(idx), m_pair * 2 + m_phase);
            check(cur_req, int'(field), m_field);
            check("R2", int'(gain), gain_of(int'(idx)));
        end
    end

    task automatic pixels(int n, bit v);
        repeat (n) begin @(negedge clk); pix_vld = v; end
    endtask

    task automatic sync_pulse(bit v, bit h, int w);
        @(negedge clk);
        pix_vld = 1'b0;
        if (v) vd = 1'b1;
        if (h) hd = 1'b1;
        repeat (w) @(negedge clk);
        vd = 1'b0; hd = 1'b0;
    endtask

    task automatic frame(int lines, int px);
        sync_pulse(1, 0, 3);
        pixels(px, 1);
        for (int l = 1; l < lines; l++) begin
            sync_pulse(0, 1, 2);
            pixels(px + l, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        g01 = {9'd300, 9'd17};
        g23 = {9'd511, 9'd128};
        repeat (3) @(negedge clk);
        check("R1", int'(field), 0);
        check("R1", int'(idx), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", int'(idx), 0);

        cur_req = "R3";
        pixels(5, 1); pixels(4, 0); pixels(3, 1);

        cur_req = "R5"; mode = 2'd0;
        frame(4, 7); frame(3, 6);

        cur_req = "R10";
        pixels(3, 1); sync_pulse(0, 1, 1); pixels(1, 0);
        check("R10", int'(idx[0]), 0);

        cur_req = "R6"; mode = 2'd1;
        frame(3, 5); frame(3, 5); frame(2, 4);

        cur_req = "R7"; mode = 2'd2;
        frame(3, 5); frame(3, 5); frame(3, 5); frame(2, 5);

        cur_req = "R8";
        pixels(3, 1); sync_pulse(1, 1, 2); pixels(4, 1);
        sync_pulse(1, 1, 2); pixels(2, 1);

        cur_req = "R9"; mode = 2'd3;
        frame(3, 6);
        check("R9", int'(field), 0);

        cur_req = "R4"; mode = 2'd0;
        @(negedge clk); vd = 1'b1; hd = 1'b1;
        pixels(9, 1);
        check("R4", int'(field), 0);
        @(negedge clk); vd = 1'b0; pix_vld = 1'b0;
        @(negedge clk); hd = 1'b0;
        pixels(3, 1);

        cur_req = "R2";
        g01 = {9'd1, 9'd2}; pixels(3, 1);
        g23 = {9'd77, 9'd450}; sync_pulse(0, 1, 1); pixels(3, 1);

        cur_req = "R11"; mode = 2'd2;
        frame(2, 3); frame(2, 3); frame(2, 3);
        mode = 2'd1; frame(2, 3);
        check("R11", int'(field != 2'd3), 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule